// File: doc/BRIEF.md
# Reorder Buffer with Issue Scheduler

This block is the circular reorder buffer of a single-issue, speculative, out-of-order core, together with the logic that chooses the next operation to execute. Each cycle it can take one instruction at dispatch, in program order, and hand back the slot number, or tag, that the rest of the pipeline uses for it. A wakeup port marks an entry's operands as available. A completion port marks an entry as finished and says whether it was a mispredicted branch.

Each cycle the scheduler offers one ready entry on the issue port. Two separate selection paths feed it. Loads and stores leave strictly in program order among themselves and may go ahead of unresolved branches. All other operations leave as soon as they are ready, oldest first. A coprocessor-control operation acts as a barrier: it waits until it is the oldest entry, and nothing younger issues while it remains in the buffer.

Finished entries retire from the head, one per cycle. A retiring store is the moment the store is released to memory. A retiring mispredicted branch squashes every younger entry, and dispatch resumes at the slot just after the branch.

Top module: `rob_sched`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `iss_valid` and `ret_valid` are 0.
- R2: Accepted dispatches receive consecutive tags 0,1,…,DEPTH-1, wrapping back to 0. When DEPTH entries are held, `disp_ready` is 0 and a dispatch request is ignored.
- R3: Only a valid entry that has not yet issued and whose operands are ready may issue. Operands become ready through `disp_rdy`=1 or a wakeup naming the tag. Each entry issues at most once.
- R4: Among ready non-memory entries (kind 2'b00), the oldest is issued first, even when older entries are still waiting.
- R5: Memory entries (kind 2'b01 load, 2'b10 store) issue in program order among themselves: a ready memory entry waits while any older memory entry has not issued. Memory entries may issue before older branches complete.
- R6: When both paths have a candidate, the older of the two is issued.
- R7: A coprocessor-control entry (kind 2'b11) issues only when it is at the head. No entry younger than it issues while it is in the buffer.
- R8: Entries retire in program order, one per cycle, only once completed. `ret_store` is 1 exactly when a store retires, and stores are never released before that.
- R9: When a branch completed with `cmpl_mispred`=1 retires, `ret_mispred` is 1. All younger entries are discarded, never issuing or retiring, and the next dispatch receives the tag after the branch.
- R10: Age ordering is correct across the wrap point: an entry in slot 0 dispatched after slot DEPTH-1 counts as younger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Operation class: 00 other, 01 load, 10 store, 11 coprocessor control |
| disp_rdy | input | 1 | Operands already available at dispatch |
| disp_ready | output | 1 | Buffer can accept a dispatch this cycle |
| disp_tag | output | TW | Tag given to the dispatched entry |
| wake_valid | input | 1 | Operand wakeup strobe |
| wake_tag | input | TW | Entry whose operands became ready |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_tag | input | TW | Entry that finished |
| cmpl_mispred | input | 1 | Finished entry was a mispredicted branch |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_tag | output | TW | Tag of the issuing entry |
| iss_kind | output | 2 | Class of the issuing entry |
| ret_valid | output | 1 | The head entry retires this cycle |
| ret_tag | output | TW | Tag of the retiring entry |
| ret_store | output | 1 | Retiring entry is a store, released to memory now |
| ret_mispred | output | 1 | Retiring entry triggers a squash of younger entries |

## Verification
The bench builds the block with the default depth of 12, so TW is 4. With that depth, filling the buffer, making a stalled dispatch and wrapping the tail past slot 11 take only a few dozen cycles. A load in slot 11 and a younger load placed in slot 0 then test the age ordering across the wrap directly. Squash tests run from a freshly reset buffer, so the expected restart tags are small and easy to predict.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer and its scheduler.
// Assumes a two-bit operation class travels with every dispatched entry.
package rob_pkg;

    typedef enum logic [1:0] {
        K_OTHER = 2'b00,
        K_LOAD  = 2'b01,
        K_STORE = 2'b10,
        K_CTRL  = 2'b11
    } op_kind_t;

    // True for the classes that must leave in program order
    function automatic logic kind_is_mem(input logic [1:0] k);
        return (k == K_LOAD) || (k == K_STORE);
    endfunction

endpackage

// File: rtl/rob_ptr.sv
// Circular pointer with a wrap bit, so a full buffer and an empty one
// can be told apart. A load takes priority over an increment.
module rob_ptr #(
    parameter int DEPTH = 12,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          load,
    input  logic [TW-1:0] ld_idx,
    input  logic          ld_wrap,
    output logic [TW-1:0] idx,
    output logic          wrap,
    output logic [TW-1:0] nxt_idx,
    output logic          nxt_wrap
);

    // Successor position, folding at DEPTH-1
    always_comb begin
        if (idx == TW'(DEPTH - 1)) begin
            nxt_idx  = '0;
            nxt_wrap = ~wrap;
        end else begin
            nxt_idx  = idx + 1'b1;
            nxt_wrap = wrap;
        end
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            wrap <= 1'b0;
        end else if (load) begin
            idx  <= ld_idx;
            wrap <= ld_wrap;
        end else if (inc) begin
            idx  <= nxt_idx;
            wrap <= nxt_wrap;
        end
    end

endmodule

// File: rtl/rob_elig.sv
// Per-entry issue eligibility. It splits the requests into a
// memory path (oldest unissued memory entry only) and a path for the
// other classes. Ages are offsets from the head, which absorbs the wrap.
// Assumes that slots outside head..tail have their valid bit cleared.
module rob_elig #(
    parameter int DEPTH = 12,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic [TW-1:0]          head,
    input  logic [DEPTH-1:0]       valid,
    input  logic [DEPTH-1:0]       rdy,
    input  logic [DEPTH-1:0]       issued,
    input  logic [DEPTH-1:0][1:0]  kind,
    output logic [DEPTH-1:0]       mem_req,
    output logic [DEPTH-1:0]       oth_req
);
    import rob_pkg::*;

    logic [TW-1:0]    age [DEPTH];
    logic [DEPTH-1:0] mem_wait;
    logic [DEPTH-1:0] ctl_block;

    // Age of every slot relative to the head
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (i >= int'(head)) age[i] = TW'(i - int'(head));
            else                 age[i] = TW'(i + DEPTH - int'(head));
        end
    end

    // Older unissued memory entries and older control barriers, per slot
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_wait[i]  = 1'b0;
            ctl_block[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (valid[j] && age[j] < age[i]) begin
                    if (kind_is_mem(kind[j]) && !issued[j]) mem_wait[i] = 1'b1;
                    if (kind[j] == K_CTRL) ctl_block[i] = 1'b1;
                end
            end
        end
    end

    // Final request vectors for the two selection paths
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic ok;
            ok = valid[i] && rdy[i] && !issued[i] && !ctl_block[i];
            mem_req[i] = ok && kind_is_mem(kind[i]) && !mem_wait[i];
            oth_req[i] = ok && ((kind[i] == K_OTHER) ||
                                (kind[i] == K_CTRL && age[i] == '0));
        end
    end

endmodule

// File: rtl/rob_age_pick.sv
// Picks the oldest set request, scanning slots in age order from the head.
// Returns the slot and its age, so two pickers can be compared.
module rob_age_pick #(
    parameter int DEPTH = 12,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic [TW-1:0]    head,
    input  logic [DEPTH-1:0] req,
    output logic             found,
    output logic [TW-1:0]    sel,
    output logic [TW-1:0]    sel_age
);

    // Youngest to oldest, so the last hit is the oldest one
    always_comb begin
        found   = 1'b0;
        sel     = '0;
        sel_age = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            int s;
            s = int'(head) + k;
            if (s >= DEPTH) s = s - DEPTH;
            if (req[s]) begin
                found   = 1'b1;
                sel     = TW'(s);
                sel_age = TW'(k);
            end
        end
    end

endmodule

// File: rtl/rob_sched.sv
// Reorder buffer with a single-issue scheduler. Entries are allocated at
// the tail in program order, issue out of order through two selection
// paths (memory in order, others oldest-ready), and retire from the head.
// A retiring mispredicted branch empties every younger slot.
// Assumes wakeups and completions name live tags, and that completion
// follows issue.
module rob_sched #(
    parameter int DEPTH = 12,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic [1:0]    disp_kind,
    input  logic          disp_rdy,
    output logic          disp_ready,
    output logic [TW-1:0] disp_tag,
    input  logic          wake_valid,
    input  logic [TW-1:0] wake_tag,
    input  logic          cmpl_valid,
    input  logic [TW-1:0] cmpl_tag,
    input  logic          cmpl_mispred,
    output logic          iss_valid,
    output logic [TW-1:0] iss_tag,
    output logic [1:0]    iss_kind,
    output logic          ret_valid,
    output logic [TW-1:0] ret_tag,
    output logic          ret_store,
    output logic          ret_mispred
);
    import rob_pkg::*;

    logic [DEPTH-1:0]      ent_valid, ent_rdy, ent_issued, ent_done, ent_mis;
    logic [DEPTH-1:0][1:0] ent_kind;

    logic [TW-1:0] head_idx, head_nidx, tail_idx, tail_nidx;
    logic          head_wrap, head_nwrap, tail_wrap, tail_nwrap;
    logic          full, disp_fire, squash;

    logic [DEPTH-1:0] mem_req, oth_req;
    logic             mem_found, oth_found, take_mem;
    logic [TW-1:0]    mem_sel, oth_sel, mem_age, oth_age;

    rob_ptr #(.DEPTH(DEPTH), .TW(TW)) u_head (
        .clk(clk), .rst_n(rst_n), .inc(ret_valid), .load(1'b0),
        .ld_idx('0), .ld_wrap(1'b0),
        .idx(head_idx), .wrap(head_wrap),
        .nxt_idx(head_nidx), .nxt_wrap(head_nwrap)
    );

    rob_ptr #(.DEPTH(DEPTH), .TW(TW)) u_tail (
        .clk(clk), .rst_n(rst_n), .inc(disp_fire), .load(squash),
        .ld_idx(head_nidx), .ld_wrap(head_nwrap),
        .idx(tail_idx), .wrap(tail_wrap),
        .nxt_idx(tail_nidx), .nxt_wrap(tail_nwrap)
    );

    // Occupancy and the dispatch handshake
    always_comb begin
        full       = (head_idx == tail_idx) && (head_wrap != tail_wrap);
        disp_ready = !full && !squash;
        disp_fire  = disp_valid && disp_ready;
        disp_tag   = tail_idx;
    end

    // Retirement at the head
    always_comb begin
        ret_valid   = ent_valid[head_idx] && ent_done[head_idx];
        ret_tag     = head_idx;
        ret_store   = ret_valid && (ent_kind[head_idx] == K_STORE);
        ret_mispred = ret_valid && ent_mis[head_idx];
        squash      = ret_mispred;
    end

    rob_elig #(.DEPTH(DEPTH), .TW(TW)) u_elig (
        .head(head_idx), .valid(ent_valid), .rdy(ent_rdy),
        .issued(ent_issued), .kind(ent_kind),
        .mem_req(mem_req), .oth_req(oth_req)
    );

    rob_age_pick #(.DEPTH(DEPTH), .TW(TW)) u_pick_mem (
        .head(head_idx), .req(mem_req),
        .found(mem_found), .sel(mem_sel), .sel_age(mem_age)
    );

    rob_age_pick #(.DEPTH(DEPTH), .TW(TW)) u_pick_oth (
        .head(head_idx), .req(oth_req),
        .found(oth_found), .sel(oth_sel), .sel_age(oth_age)
    );

    // Older of the two path winners goes to the issue port
    always_comb begin
        take_mem  = mem_found && (!oth_found || mem_age < oth_age);
        iss_valid = mem_found || oth_found;
        iss_tag   = take_mem ? mem_sel : oth_sel;
        iss_kind  = ent_kind[iss_tag];
    end

    // Entry state: allocation, wakeup, issue, completion, retire, squash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= '0;
            ent_rdy    <= '0;
            ent_issued <= '0;
            ent_done   <= '0;
            ent_mis    <= '0;
            ent_kind   <= '0;
        end else if (squash) begin
            ent_valid <= '0;
        end else begin
            if (wake_valid && int'(wake_tag) < DEPTH) ent_rdy[wake_tag] <= 1'b1;
            if (iss_valid) ent_issued[iss_tag] <= 1'b1;
            if (cmpl_valid && int'(cmpl_tag) < DEPTH) begin
                ent_done[cmpl_tag] <= 1'b1;
                ent_mis[cmpl_tag]  <= cmpl_mispred;
            end
            if (ret_valid) ent_valid[head_idx] <= 1'b0;
            if (disp_fire) begin
                ent_valid[tail_idx]  <= 1'b1;
                ent_rdy[tail_idx]    <= disp_rdy;
                ent_issued[tail_idx] <= 1'b0;
                ent_done[tail_idx]   <= 1'b0;
                ent_mis[tail_idx]    <= 1'b0;
                ent_kind[tail_idx]   <= disp_kind;
            end
        end
    end

endmodule

// File: rtl/rob_sched_chk.sv
// Protocol checks for rob_sched, attached to every instance by bind.
// Observes ports plus the head pointer.
module rob_sched_chk #(
    parameter int DEPTH = 12,
    parameter int TW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          disp_valid,
    input logic          disp_ready,
    input logic [TW-1:0] disp_tag,
    input logic          iss_valid,
    input logic [TW-1:0] iss_tag,
    input logic [1:0]    iss_kind,
    input logic          ret_valid,
    input logic [TW-1:0] ret_tag,
    input logic          ret_mispred,
    input logic [TW-1:0] head_idx
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!iss_valid && !ret_valid && disp_ready));

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
        disp_tag == (($past(disp_tag) == TW'(DEPTH - 1)) ? '0 : $past(disp_tag) + 1'b1));

    // R3
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !(iss_valid && iss_tag == $past(iss_tag)));

    // R7
    ctrl_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind == 2'b11) |-> iss_tag == head_idx);

    // R8
    retire_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !(ret_valid && ret_tag == $past(ret_tag)));

    // R9
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_mispred |=> (!iss_valid && !ret_valid));

endmodule

bind rob_sched rob_sched_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_kind(iss_kind),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_mispred(ret_mispred),
    .head_idx(head_idx)
);

// File: tb/sim_rob_sched.sv
// Directed bench for rob_sched. Issue and retire events are logged at the
// falling edge; every scenario task checks the logs and the ports.
module sim_rob_sched;
    localparam int DEPTH = 12;
    localparam int TW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0;
    logic [1:0]    disp_kind = 2'b00;
    logic          disp_rdy = 1'b0;
    logic          disp_ready;
    logic [TW-1:0] disp_tag;
    logic          wake_valid = 1'b0;
    logic [TW-1:0] wake_tag = '0;
    logic          cmpl_valid = 1'b0;
    logic [TW-1:0] cmpl_tag = '0;
    logic          cmpl_mispred = 1'b0;
    logic          iss_valid;
    logic [TW-1:0] iss_tag;
    logic [1:0]    iss_kind;
    logic          ret_valid;
    logic [TW-1:0] ret_tag;
    logic          ret_store;
    logic          ret_mispred;

    int n_chk = 0;
    int n_bad = 0;
    int iss_log [64];
    int ret_log [64];
    int ret_st  [64];
    int ret_mp  [64];
    int iss_n = 0;
    int ret_n = 0;
    int st_n  = 0;

    always #10 clk = ~clk;

    rob_sched #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_rdy(disp_rdy),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_mispred(cmpl_mispred),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_kind(iss_kind),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_store(ret_store),
        .ret_mispred(ret_mispred)
    );

    // Event logger: outputs depend only on registered state
    always @(negedge clk) begin
        if (!rst_n) begin
            iss_n = 0; ret_n = 0; st_n = 0;
        end else begin
            if (iss_valid && iss_n < 64) begin
                iss_log[iss_n] = int'(iss_tag); iss_n++;
            end
            if (ret_valid && ret_n < 64) begin
                ret_log[ret_n] = int'(ret_tag);
                ret_st[ret_n]  = int'(ret_store);
                ret_mp[ret_n]  = int'(ret_mispred);
                ret_n++;
            end
            if (ret_store && !ret_valid) st_n++;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
    endtask

    task automatic dispatch(input logic [1:0] k, input logic r, output int tag);
        disp_valid = 1'b1; disp_kind = k; disp_rdy = r;
        #1 tag = int'(disp_tag);
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic wake(input int t);
        wake_valid = 1'b1; wake_tag = TW'(t);
        @(negedge clk);
        wake_valid = 1'b0;
    endtask

    task automatic complete(input int t, input logic mis);
        cmpl_valid = 1'b1; cmpl_tag = TW'(t); cmpl_mispred = mis;
        @(negedge clk);
        cmpl_valid = 1'b0; cmpl_mispred = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk_eq("R1 disp_ready", int'(disp_ready), 1);
        chk_eq("R1 disp_tag", int'(disp_tag), 0);
        chk_eq("R1 iss_valid", int'(iss_valid), 0);
        chk_eq("R1 ret_valid", int'(ret_valid), 0);
    endtask

    task automatic t_out_of_order();
        int a, b;
        do_reset();
        dispatch(2'b00, 1'b0, a);
        dispatch(2'b00, 1'b1, b);
        chk_eq("R2 first tag", a, 0);
        chk_eq("R2 second tag", b, 1);
        cycles(3);
        chk_eq("R3 only ready issues", iss_n, 1);
        chk_eq("R4 younger ready first", iss_log[0], 1);
        wake(0);
        cycles(2);
        chk_eq("R3 wakeup enables issue", iss_log[1], 0);
        complete(1, 1'b0);
        cycles(2);
        chk_eq("R8 no retire past unfinished head", ret_n, 0);
        complete(0, 1'b0);
        cycles(3);
        chk_eq("R8 retire count", ret_n, 2);
        chk_eq("R8 retire order first", ret_log[0], 0);
        chk_eq("R8 retire order second", ret_log[1], 1);
        chk_eq("R3 issued once each", iss_n, 2);
    endtask

    task automatic t_mem_order();
        int t;
        do_reset();
        dispatch(2'b01, 1'b0, t);
        dispatch(2'b10, 1'b1, t);
        dispatch(2'b00, 1'b1, t);
        cycles(3);
        chk_eq("R5 store waits for older load", iss_n, 1);
        chk_eq("R5 other op passes", iss_log[0], 2);
        wake(0);
        cycles(3);
        chk_eq("R5 load next", iss_log[1], 0);
        chk_eq("R5 store after load", iss_log[2], 1);
        chk_eq("R8 store held until retire", st_n + ret_n, 0);
        complete(0, 1'b0);
        complete(1, 1'b0);
        complete(2, 1'b0);
        cycles(3);
        chk_eq("R8 three retired", ret_n, 3);
        chk_eq("R8 load not a store", ret_st[0], 0);
        chk_eq("R8 store released", ret_st[1], 1);
        chk_eq("R8 other not a store", ret_st[2], 0);
    endtask

    task automatic t_speculative();
        int t;
        do_reset();
        dispatch(2'b00, 1'b1, t);
        dispatch(2'b01, 1'b1, t);
        cycles(3);
        chk_eq("R5 load issues before branch completes", iss_n, 2);
        chk_eq("R6 older first", iss_log[0], 0);
        chk_eq("R5 speculative load", iss_log[1], 1);
    endtask

    task automatic t_barrier();
        int t;
        do_reset();
        dispatch(2'b11, 1'b0, t);
        dispatch(2'b00, 1'b1, t);
        dispatch(2'b00, 1'b1, t);
        dispatch(2'b01, 1'b1, t);
        cycles(3);
        chk_eq("R7 younger blocked by barrier", iss_n, 0);
        wake(0);
        cycles(3);
        chk_eq("R7 barrier issues at head", iss_n, 1);
        chk_eq("R7 barrier tag", iss_log[0], 0);
        complete(0, 1'b0);
        cycles(5);
        chk_eq("R4 released entries count", iss_n, 4);
        chk_eq("R4 oldest first", iss_log[1], 1);
        chk_eq("R4 then next", iss_log[2], 2);
        chk_eq("R6 memory in age order", iss_log[3], 3);
        do_reset();
        dispatch(2'b00, 1'b0, t);
        dispatch(2'b11, 1'b1, t);
        cycles(3);
        chk_eq("R7 barrier waits off head", iss_n, 0);
        wake(0);
        cycles(3);
        chk_eq("R7 only older op issued", iss_n, 1);
        complete(0, 1'b0);
        cycles(3);
        chk_eq("R7 barrier after head retires", iss_n, 2);
        chk_eq("R7 barrier tag at head", iss_log[1], 1);
    endtask

    task automatic t_full_wrap();
        int t;
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) dispatch(2'b00, 1'b0, t);
        dispatch(2'b01, 1'b0, t);
        chk_eq("R2 last tag", t, DEPTH - 1);
        #1 chk_eq("R2 full stalls", int'(disp_ready), 0);
        dispatch(2'b00, 1'b1, t);
        cycles(3);
        chk_eq("R2 dispatch while full ignored", iss_n, 0);
        wake(0);
        cycles(2);
        complete(0, 1'b0);
        cycles(3);
        chk_eq("R8 head retired", ret_n, 1);
        #1 chk_eq("R2 space after retire", int'(disp_ready), 1);
        dispatch(2'b01, 1'b1, t);
        chk_eq("R2 tag wraps", t, 0);
        cycles(3);
        chk_eq("R10 wrapped load waits for older load", iss_n, 1);
        wake(DEPTH - 1);
        cycles(4);
        chk_eq("R10 issue count", iss_n, 3);
        chk_eq("R10 older load first", iss_log[1], DEPTH - 1);
        chk_eq("R10 wrapped load second", iss_log[2], 0);
    endtask

    task automatic t_mispredict();
        int t;
        do_reset();
        dispatch(2'b00, 1'b1, t);
        dispatch(2'b00, 1'b0, t);
        dispatch(2'b01, 1'b0, t);
        cycles(2);
        chk_eq("R9 branch issued", iss_log[0], 0);
        complete(0, 1'b1);
        cycles(3);
        chk_eq("R9 branch retired", ret_n, 1);
        chk_eq("R9 squash flag", ret_mp[0], 1);
        #1 chk_eq("R9 restart tag", int'(disp_tag), 1);
        wake(1);
        wake(2);
        cycles(3);
        chk_eq("R9 squashed never issue", iss_n, 1);
        chk_eq("R9 squashed never retire", ret_n, 1);
        dispatch(2'b00, 1'b1, t);
        chk_eq("R9 new entry tag", t, 1);
        cycles(2);
        chk_eq("R9 new entry issues", iss_log[1], 1);
    endtask

    initial begin
        t_reset();
        t_out_of_order();
        t_mem_order();
        t_speculative();
        t_barrier();
        t_full_wrap();
        t_mispredict();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule